// File: doc/BRIEF.md
# Serial Channel Line-Format Configuration Sequencer

This block brings one channel of a four-channel, 16550-compatible UART into a chosen line format. A single-cycle `start` pulse captures the channel number, the baud divisor byte, the word-length code, the stop-bit flag and the parity code. The block then drives a fixed series of seven register accesses to an external bus-cycle engine and pulses `done` when the last one completes.

The sequence works as follows:

- It opens the divisor bank by setting bit 7 of the line control register (LCR).
- It loads the divisor, low and high bytes.
- It reads the LCR back and closes the bank in a read-modify-write.
- It enables the FIFOs.

After every access the block waits for a fixed number of idle cycles before it issues the next one.

The engine interface is a valid/ready request channel. The block raises `req_valid` and presents `req_chan`, `req_addr`, `req_write` and `req_wdata`. Back-pressure from the engine is absorbed by holding all of these fields unchanged until the engine asserts `req_ready`. A transfer takes place on a clock edge where both `req_valid` and `req_ready` are high. For a read, the engine must place the register contents on `rd_data` in that same cycle. `rd_data` is ignored at all other times.

Top module: `uart_cfg_seq`

## Requirements
- R1: After reset `busy`, `done` and `req_valid` are low.
- R2: A `start` seen while idle raises `busy` and `req_valid` in the next cycle. The seven accesses follow in this order (direction, address):
  1. read 3
  2. write 3
  3. write 1
  4. write 0
  5. read 3
  6. write 3
  7. write 2
- R3: The write to address 3 that opens the bank carries 0x80. The write to address 1 carries 0x00. The write to address 0 carries the captured divisor byte.
- R4: The second write to address 3 carries `(R & 0x7F) | (parity << 3) | (stop << 2) | len`, where R is `rd_data` from the second read. This clears bit 7, ORs the word-length code into bits [1:0], the stop flag into bit 2 and the 3-bit parity code into bits [5:3], and keeps bit 6.
- R5: The value returned by the first read has no effect on any later write.
- R6: The last access writes 0x01 to address 2.
- R7: After each transfer, `req_valid` stays low for exactly `GAP_CYCLES` cycles before the next request is raised.
- R8: While `req_valid` is high and `req_ready` is low, `req_valid`, `req_chan`, `req_addr`, `req_write` and `req_wdata` keep their values.
- R9: A `start` that arrives while `busy` is high is ignored. Its channel and format values appear in no request, and it does not restart the sequence.
- R10: `done` is high for exactly one cycle: the cycle right after the final transfer. `busy` is high from the cycle after `start` up to that cycle, and low from then on.
- R11: Every request carries the channel number captured at `start`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | One-cycle start pulse |
| chan_sel | input | CHAN_W | Target channel |
| baud_div | input | 8 | Divisor low byte |
| len_code | input | 2 | Word-length code |
| stop_flag | input | 1 | Stop-bit select |
| parity_code | input | 3 | Parity code |
| busy | output | 1 | Sequence in progress |
| done | output | 1 | One-cycle completion pulse |
| req_valid | output | 1 | Request valid |
| req_ready | input | 1 | Request accepted by engine |
| req_chan | output | CHAN_W | Channel of request |
| req_addr | output | 3 | Register address |
| req_write | output | 1 | 1 = write, 0 = read |
| req_wdata | output | 8 | Write data |
| rd_data | input | 8 | Read data, valid during a read transfer |

## Verification
The engine model holds `req_ready` low for varying numbers of cycles. A design that let its request fields drift before acceptance, or counted the idle gap from the request instead of from the transfer, would log the wrong accesses or the wrong gap lengths.

The model returns non-zero values on both reads: junk on the first, and set bits 6, 7 and low-field bits on the second. This exposes:

- a design that builds the line word from the wrong read;
- a design that fails to clear bit 7;
- a design that masks bits instead of ORing them;
- a design that drops bit 6.

A second `start` with a different channel is injected mid-sequence. A design that re-latched or restarted on it would retarget later requests or issue more than seven accesses.

// File: rtl/cfg_seq_pkg.sv
package cfg_seq_pkg;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_ISSUE = 2'd1,
    ST_GAP   = 2'd2
  } seq_state_t;

  localparam int STEP_COUNT = 7;
  localparam int STEP_W     = $clog2(STEP_COUNT);
  localparam int REG_W      = 8;
  localparam int ADDR_W     = 3;

  // Step order is behaviour: it must not be rearranged.
  typedef enum logic [STEP_W-1:0] {
    SP_PROBE  = 3'd0,
    SP_OPEN   = 3'd1,
    SP_DIVHI  = 3'd2,
    SP_DIVLO  = 3'd3,
    SP_REREAD = 3'd4,
    SP_LINE   = 3'd5,
    SP_FIFO   = 3'd6
  } step_t;

  localparam step_t LAST_STEP = SP_FIFO;

  typedef struct packed {
    logic              is_write;
    logic [ADDR_W-1:0] addr;
    logic [REG_W-1:0]  data;
  } bus_op_t;

  localparam logic [ADDR_W-1:0] A_DIV_LO   = 3'd0;
  localparam logic [ADDR_W-1:0] A_DIV_HI   = 3'd1;
  localparam logic [ADDR_W-1:0] A_FIFO_CTL = 3'd2;
  localparam logic [ADDR_W-1:0] A_LINE_CTL = 3'd3;

  localparam logic [REG_W-1:0] BANK_OPEN_WORD = 8'h80;
  localparam logic [REG_W-1:0] DIV_HI_WORD    = 8'h00;
  localparam logic [REG_W-1:0] FIFO_ON_WORD   = 8'h01;

  // Merge the format fields into a read-back line word with bank bit cleared.
  function automatic logic [REG_W-1:0] merge_line(
    input logic [REG_W-1:0] readback,
    input logic [1:0]       len,
    input logic             stop,
    input logic [2:0]       par
  );
    logic [REG_W-1:0] fmt;
    fmt = {2'b00, par, stop, len};
    return (readback & 8'h7F) | fmt;
  endfunction

endpackage

// File: rtl/cfg_step_decode.sv
module cfg_step_decode
  import cfg_seq_pkg::*;
(
  input  step_t            step,
  input  logic [REG_W-1:0] div_byte,
  input  logic [REG_W-1:0] line_word,
  output bus_op_t          op
);

  always_comb begin
    op = '{is_write: 1'b0, addr: A_LINE_CTL, data: '0};
    unique case (step)
      SP_PROBE:  op = '{is_write: 1'b0, addr: A_LINE_CTL, data: '0};
      SP_OPEN:   op = '{is_write: 1'b1, addr: A_LINE_CTL, data: BANK_OPEN_WORD};
      SP_DIVHI:  op = '{is_write: 1'b1, addr: A_DIV_HI,   data: DIV_HI_WORD};
      SP_DIVLO:  op = '{is_write: 1'b1, addr: A_DIV_LO,   data: div_byte};
      SP_REREAD: op = '{is_write: 1'b0, addr: A_LINE_CTL, data: '0};
      SP_LINE:   op = '{is_write: 1'b1, addr: A_LINE_CTL, data: line_word};
      SP_FIFO:   op = '{is_write: 1'b1, addr: A_FIFO_CTL, data: FIFO_ON_WORD};
      default:   op = '{is_write: 1'b0, addr: A_LINE_CTL, data: '0};
    endcase
  end

endmodule

// File: rtl/cfg_gap_timer.sv
module cfg_gap_timer #(
  parameter int GAP_CYCLES = 20
) (
  input  logic clk,
  input  logic rst_n,
  input  logic load,
  output logic expired
);

  localparam int CNT_W = $clog2(GAP_CYCLES + 1);
  localparam logic [CNT_W-1:0] GAP_INIT = CNT_W'(GAP_CYCLES);

  logic [CNT_W-1:0] remain;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)              remain <= '0;
    else if (load)           remain <= GAP_INIT;
    else if (remain != '0)   remain <= remain - 1'b1;
  end

  assign expired = (remain == CNT_W'(1));

  // R7
  gap_drain_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (expired && !load) |=> (remain == '0));

  // R7
  gap_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    load |=> (remain == GAP_INIT));

endmodule

// File: rtl/uart_cfg_seq.sv
module uart_cfg_seq
  import cfg_seq_pkg::*;
#(
  parameter int CHAN_W     = 2,
  parameter int GAP_CYCLES = 20
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [CHAN_W-1:0] chan_sel,
  input  logic [7:0]        baud_div,
  input  logic [1:0]        len_code,
  input  logic              stop_flag,
  input  logic [2:0]        parity_code,
  output logic              busy,
  output logic              done,
  output logic              req_valid,
  input  logic              req_ready,
  output logic [CHAN_W-1:0] req_chan,
  output logic [2:0]        req_addr,
  output logic              req_write,
  output logic [7:0]        req_wdata,
  input  logic [7:0]        rd_data
);

  seq_state_t        state;
  step_t             step;
  logic [CHAN_W-1:0] chan_q;
  logic [REG_W-1:0]  div_q;
  logic [1:0]        len_q;
  logic              stop_q;
  logic [2:0]        par_q;
  logic [REG_W-1:0]  readback_q;
  logic              accept;
  logic              xfer;
  logic              gap_load;
  logic              gap_expired;
  logic [REG_W-1:0]  line_word;
  bus_op_t           op;

  assign accept    = start && (state == ST_IDLE);
  assign req_valid = (state == ST_ISSUE);
  assign xfer      = req_valid && req_ready;
  assign gap_load  = xfer && (step != LAST_STEP);
  assign line_word = merge_line(readback_q, len_q, stop_q, par_q);

  cfg_step_decode u_decode (
    .step      (step),
    .div_byte  (div_q),
    .line_word (line_word),
    .op        (op)
  );

  cfg_gap_timer #(.GAP_CYCLES(GAP_CYCLES)) u_gap (
    .clk     (clk),
    .rst_n   (rst_n),
    .load    (gap_load),
    .expired (gap_expired)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state <= ST_IDLE;
      step  <= SP_PROBE;
      done  <= 1'b0;
    end else begin
      done <= 1'b0;
      unique case (state)
        ST_IDLE: if (accept) begin
          state <= ST_ISSUE;
          step  <= SP_PROBE;
        end
        ST_ISSUE: if (xfer) begin
          if (step == LAST_STEP) begin
            state <= ST_IDLE;
            done  <= 1'b1;
          end else begin
            state <= ST_GAP;
            step  <= step_t'(step + 1'b1);
          end
        end
        ST_GAP: if (gap_expired) state <= ST_ISSUE;
        default: state <= ST_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      chan_q <= '0;
      div_q  <= '0;
      len_q  <= '0;
      stop_q <= 1'b0;
      par_q  <= '0;
    end else if (accept) begin
      chan_q <= chan_sel;
      div_q  <= baud_div;
      len_q  <= len_code;
      stop_q <= stop_flag;
      par_q  <= parity_code;
    end
  end

  // Only the second line-control read is kept; the first is discarded.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                           readback_q <= '0;
    else if (xfer && step == SP_REREAD)   readback_q <= rd_data;
  end

  assign busy      = (state != ST_IDLE);
  assign req_chan  = chan_q;
  assign req_addr  = op.addr;
  assign req_write = op.is_write;
  assign req_wdata = op.data;

  // R8
  req_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && !req_ready) |=> (req_valid && $stable(req_addr) &&
      $stable(req_wdata) && $stable(req_write) && $stable(req_chan)));

  // R2
  start_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (start && !busy) |=> (busy && req_valid));

  // R9
  start_ignored_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (start && busy) |=> $stable(req_chan));

  // R10
  done_after_fifo_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(done) |-> $past(xfer && req_write && req_addr == A_FIFO_CTL));

  // R10
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  // R4
  line_word_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && step == SP_LINE) |->
      (req_wdata[7] == 1'b0 && req_wdata[6] == readback_q[6] && req_write));

endmodule

// File: tb/test_uart_cfg_seq.sv
module test_uart_cfg_seq;
  localparam int CLK_PERIOD = 10;
  localparam int GAP        = 4;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       start = 1'b0;
  logic [1:0] chan_sel = '0;
  logic [7:0] baud_div = '0;
  logic [1:0] len_code = '0;
  logic       stop_flag = 1'b0;
  logic [2:0] parity_code = '0;
  logic       busy, done, req_valid, req_write;
  logic       req_ready = 1'b0;
  logic [1:0] req_chan;
  logic [2:0] req_addr;
  logic [7:0] req_wdata;
  logic [7:0] rd_data = '0;

  uart_cfg_seq #(.CHAN_W(2), .GAP_CYCLES(GAP)) i_uart_cfg_seq (
    .clk(clk), .rst_n(rst_n), .start(start), .chan_sel(chan_sel),
    .baud_div(baud_div), .len_code(len_code), .stop_flag(stop_flag),
    .parity_code(parity_code), .busy(busy), .done(done),
    .req_valid(req_valid), .req_ready(req_ready), .req_chan(req_chan),
    .req_addr(req_addr), .req_write(req_write), .req_wdata(req_wdata),
    .rd_data(rd_data)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  int cyc = 0;
  always @(posedge clk) cyc <= cyc + 1;

  int n_chk = 0, n_bad = 0;
  bit finished = 0;

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: actual=0x%0h expected=0x%0h", tag, act, exp);
    end
  endtask

  // Engine model state
  int  lat = 0;
  logic [7:0] rb_first = 0, rb_second = 0;
  int  n_log = 0, n_rd = 0, wcnt = 0, lowcnt = 0, hold_bad = 0;
  bit  pend = 0;
  logic [2:0] lg_addr [0:15];
  logic       lg_wr   [0:15];
  logic [7:0] lg_data [0:15];
  logic [1:0] lg_chan [0:15];
  int         lg_gap  [0:15];
  int         lg_cyc  [0:15];
  logic [2:0] c_addr; logic c_wr; logic [7:0] c_data; logic [1:0] c_chan;

  initial begin
    forever begin
      @(negedge clk);
      if (req_ready) req_ready = 1'b0;
      if (req_valid) begin
        if (!pend) begin
          pend = 1; wcnt = 0;
          c_addr = req_addr; c_wr = req_write; c_data = req_wdata; c_chan = req_chan;
          if (n_log < 16) lg_gap[n_log] = lowcnt;
        end else if (c_addr !== req_addr || c_wr !== req_write ||
                     c_data !== req_wdata || c_chan !== req_chan) begin
          hold_bad++;
        end
        if (wcnt >= lat) begin
          req_ready = 1'b1;
          if (!req_write) begin
            rd_data = (n_rd == 0) ? rb_first : rb_second;
            n_rd++;
          end else rd_data = 8'hEE;
          if (n_log < 16) begin
            lg_addr[n_log] = req_addr; lg_wr[n_log] = req_write;
            lg_data[n_log] = req_wdata; lg_chan[n_log] = req_chan;
            lg_cyc[n_log] = cyc;
          end
          n_log++; pend = 0; lowcnt = 0;
        end else wcnt++;
      end else if (n_log > 0) lowcnt++;
    end
  end

  task automatic pulse_start(input logic [1:0] ch, input logic [7:0] dv,
                             input logic [1:0] ln, input logic sb, input logic [2:0] pc);
    @(negedge clk);
    chan_sel = ch; baud_div = dv; len_code = ln; stop_flag = sb; parity_code = pc;
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
  endtask

  // One full configuration scenario; checks R2..R11 on the logged accesses.
  task automatic run_cfg(input string name, input logic [1:0] ch, input logic [7:0] dv,
                         input logic [1:0] ln, input logic sb, input logic [2:0] pc,
                         input logic [7:0] r0, input logic [7:0] r1, input int l,
                         input bit inject);
    logic [2:0] e_addr [0:6];
    logic       e_wr   [0:6];
    logic [7:0] e_data [0:6];
    int busy_drop = 0, done_cyc = 0;
    e_addr = '{3'd3, 3'd3, 3'd1, 3'd0, 3'd3, 3'd3, 3'd2};
    e_wr   = '{1'b0, 1'b1, 1'b1, 1'b1, 1'b0, 1'b1, 1'b1};
    e_data = '{8'h00, 8'h80, 8'h00, dv,
               8'h00, (r1 & 8'h7F) | {2'b00, pc, sb, ln}, 8'h01};
    lat = l; rb_first = r0; rb_second = r1;
    n_log = 0; n_rd = 0; lowcnt = 0; hold_bad = 0; pend = 0;
    pulse_start(ch, dv, ln, sb, pc);
    // R2: busy and request raised the cycle after start
    chk(busy === 1'b1, {name, " R2 busy after start"}, busy, 1);
    if (inject) begin
      repeat (6) @(negedge clk);
      pulse_start(~ch, ~dv, ~ln, ~sb, ~pc);
    end
    while (done !== 1'b1) begin
      if (busy !== 1'b1) busy_drop++;
      @(negedge clk);
    end
    done_cyc = cyc;
    // R10
    chk(busy_drop == 0, {name, " R10 busy held until done"}, busy_drop, 0);
    chk(busy === 1'b0, {name, " R10 busy low with done"}, busy, 0);
    chk(done_cyc == lg_cyc[6] + 1, {name, " R10 done one cycle after final transfer"},
        done_cyc, lg_cyc[6] + 1);
    @(negedge clk);
    chk(done === 1'b0, {name, " R10 done single cycle"}, done, 0);
    repeat (3 * GAP) @(negedge clk);
    // R2 / R9: exactly seven accesses, no restart
    chk(n_log == 7, {name, " R2 R9 access count"}, n_log, 7);
    // R8
    chk(hold_bad == 0, {name, " R8 request held under back-pressure"}, hold_bad, 0);
    for (int i = 0; i < 7; i++) begin
      chk(lg_addr[i] == e_addr[i], $sformatf("%s R2 addr step %0d", name, i), lg_addr[i], e_addr[i]);
      chk(lg_wr[i] == e_wr[i], $sformatf("%s R2 dir step %0d", name, i), lg_wr[i], e_wr[i]);
      // R11 (and R9 when inject is set)
      chk(lg_chan[i] == ch, $sformatf("%s R11 chan step %0d", name, i), lg_chan[i], ch);
      if (e_wr[i])
        // R3 R4 R5 R6
        chk(lg_data[i] == e_data[i], $sformatf("%s R3/R4/R5/R6 data step %0d", name, i),
            lg_data[i], e_data[i]);
      if (i > 0)
        // R7
        chk(lg_gap[i] == GAP, $sformatf("%s R7 gap before step %0d", name, i), lg_gap[i], GAP);
    end
  endtask

  task automatic test_reset();
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    // R1
    chk(busy === 1'b0, "R1 busy in reset", busy, 0);
    chk(done === 1'b0, "R1 done in reset", done, 0);
    chk(req_valid === 1'b0, "R1 req_valid in reset", req_valid, 0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    chk(req_valid === 1'b0 && busy === 1'b0, "R1 idle after reset", req_valid, 0);
  endtask

  initial begin
    test_reset();
    run_cfg("basic",    2'd1, 8'h34, 2'd3, 1'b0, 3'd0, 8'h00, 8'h80, 0, 0);
    run_cfg("stall",    2'd2, 8'h0D, 2'd2, 1'b1, 3'd5, 8'hFF, 8'hC0, 3, 0);
    run_cfg("or_merge", 2'd3, 8'h1A, 2'd1, 1'b0, 3'd2, 8'h5A, 8'hC5, 1, 0);
    run_cfg("bit6_low", 2'd0, 8'hFF, 2'd0, 1'b1, 3'd7, 8'h7F, 8'h80, 2, 0);
    run_cfg("ignored",  2'd1, 8'h67, 2'd3, 1'b1, 3'd1, 8'h33, 8'h80, 2, 1);
    if (!finished) begin
      finished = 1;
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end

endmodule